// File: doc/BRIEF.md
# Page write sequencer

This block sits between a synchronous host byte bus and a byte-wide non-volatile array port. Host byte writes that fall in one 128-byte page are gathered into a local page buffer, in any order, each writing its byte at the offset given by the low seven address bits. A byte-load window restarts on every accepted byte. When the window runs out with no further byte, the sequencer commits the whole page to the array during a write cycle of fixed length. Positions the host never loaded are written as FF.

While the commit runs, `busy` is high and host reads return a status byte instead of array data. Bit 7 of that byte is the complement of bit 7 of the most recently loaded byte. Bit 6 flips on each read. Software polls either bit until the true data returns. Both durations are parameters counted in clock cycles.

Top module: `pgwr_seq`

## Requirements
- R1: Bytes loaded in any order into one page are each written to the array at {page, offset}: host_addr[17:7] is the page and host_addr[6:0] the offset.
- R2: Each page offset not loaded before the commit is written to the array as 8'hFF.
- R3: `busy` rises exactly LOAD_WIN cycles after the last accepted byte, provided no further byte is accepted in between; each accepted byte restarts the window.
- R4: `busy` stays high for exactly WR_CYC cycles. In its first PAGE_BYTES cycles, `arr_we` pulses once per cycle, at offsets 0 up to PAGE_BYTES-1 of the loaded page in rising order.
- R5: While a page is loading, a write whose page differs from the first byte's page is ignored. It sets `page_err`, which stays high until reset.
- R6: Host writes while `busy` is high are ignored: they neither reach the array nor open a new page load.
- R7: A read while `busy` is high returns bit 7 equal to the complement of bit 7 of the last loaded byte, with bits 5:0 equal to zero.
- R8: Within one busy period, bit 6 of the first status read is 0, and each further status read returns the opposite of the previous one.
- R9: A read while `busy` is low returns the array byte at host_addr on host_rdata one cycle after host_re, and host_rdata holds until the next read. After a commit, this gives the true data at the last loaded address.
- R10: After reset, busy, page_err and arr_we are 0 and host_rdata is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host byte write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 18 | Host byte address (page in 17:7, offset in 6:0) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data or status byte, valid the cycle after host_re |
| busy | output | 1 | Page commit in progress |
| page_err | output | 1 | Sticky flag for a rejected cross-page write |
| arr_we | output | 1 | Array byte write enable |
| arr_addr | output | 18 | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data for arr_addr |

## Verification
On every cycle, the assertions check the shape of the commit: the write pulse count and the busy length per commit, consecutive rising offsets, no array write outside busy, and a sticky error flag. They also check the status byte: the inverted bit 7 and the alternating bit 6 on each busy read. Other behaviour can only be shown by the directed scenarios against a bench memory. These cover the data that actually lands in the array, FF fill of unloaded offsets, the exact cycle on which the window expires and its restart, rejected cross-page writes, and writes ignored during busy.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WRITE = 2'd2
  } seq_st_e;
endpackage

// File: rtl/pgwr_tmr.sv
// Down counter: loads on start, counts while tick, reports zero.
module pgwr_tmr #(
  parameter int              CW    = 8,
  parameter logic [CW-1:0]   LOADV = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic zero
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (tick && (cnt_q != '0));
    cnt_d  = start ? LOADV : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgwr_pbuf.sv
// Page buffer with per-byte valid mask; invalid bytes read as FF.
module pgwr_pbuf #(
  parameter int PAGE_BYTES = 128,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [PAGE_BYTES-1:0] valid_q;
  logic [7:0]            data_q [PAGE_BYTES];

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    logic hit;
    logic vld_en;
    logic vld_d;
    assign hit    = ld_en && (ld_idx == IDX_W'(i));
    assign vld_en = hit || clr;
    assign vld_d  = !clr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      valid_q[i] <= 1'b0;
      else if (vld_en) valid_q[i] <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (hit) data_q[i] <= ld_data;
    end
  end

  assign rd_data = valid_q[rd_idx] ? data_q[rd_idx] : 8'hFF;
endmodule

// File: rtl/pgwr_stat.sv
// Host read path: array data when idle, polling status byte when busy.
module pgwr_stat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       rd_en,
  input  logic [7:0] arr_rdata,
  input  logic       last_b7,
  output logic [7:0] rdata
);
  logic       tgl_q, tgl_d, tgl_en;
  logic [7:0] rdata_q, rdata_d;

  always_comb begin
    tgl_en  = !busy || rd_en;
    tgl_d   = busy ? !tgl_q : 1'b0;
    rdata_d = busy ? {!last_b7, tgl_q, 6'b0} : arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgl_q <= 1'b0;
    else if (tgl_en) tgl_q <= tgl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= 8'h00;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq #(
  parameter int ADDR_W     = 18,
  parameter int PAGE_BYTES = 128,
  parameter int LOAD_WIN   = 20,
  parameter int WR_CYC     = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              busy,
  output logic              page_err,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  input  logic [7:0]        arr_rdata
);
  import pgwr_pkg::*;

  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - IDX_W;
  localparam int WIN_W  = $clog2(LOAD_WIN + 1);
  localparam int WCY_W  = $clog2(WR_CYC + 1);
  localparam logic [IDX_W:0] PAGE_CNT = (IDX_W+1)'(PAGE_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  seq_st_e          st_q, st_d;
  logic [PG_W-1:0]  page_q;
  logic [IDX_W:0]   idx_q, idx_d;
  logic             idx_en;
  logic             last_b7_q;
  logic             err_q;
  logic             acc_we, mis_we, expire, wr_done;
  logic             win_zero, wcy_zero;
  logic [PG_W-1:0]  host_page;
  logic [IDX_W-1:0] host_off;
  logic [7:0]       buf_rd;

  assign host_page = host_addr[ADDR_W-1:IDX_W];
  assign host_off  = host_addr[IDX_W-1:0];

  always_comb begin
    acc_we  = host_we && ((st_q == ST_IDLE) ||
                          ((st_q == ST_LOAD) && (host_page == page_q)));
    mis_we  = host_we && (st_q == ST_LOAD) && (host_page != page_q);
    expire  = (st_q == ST_LOAD) && win_zero && !acc_we;
    wr_done = (st_q == ST_WRITE) && wcy_zero;
  end

  // next-state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (acc_we)  st_d = ST_LOAD;
      ST_LOAD:  if (expire)  st_d = ST_WRITE;
      ST_WRITE: if (wr_done) st_d = ST_IDLE;
      default:               st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  // page register and last-loaded bit 7
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      page_q    <= '0;
      last_b7_q <= 1'b0;
    end else if (acc_we) begin
      page_q    <= host_page;
      last_b7_q <= host_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    err_q <= 1'b0;
    else if (mis_we) err_q <= 1'b1;
  end

  // commit offset counter
  always_comb begin
    idx_en = expire || ((st_q == ST_WRITE) && (idx_q < PAGE_CNT));
    idx_d  = expire ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  pgwr_tmr #(.CW(WIN_W), .LOADV(WIN_W'(LOAD_WIN - 1))) u_win (
    .clk(clk), .rst_n(rst_q_n), .start(acc_we),
    .tick(st_q == ST_LOAD), .zero(win_zero)
  );

  pgwr_tmr #(.CW(WCY_W), .LOADV(WCY_W'(WR_CYC - 1))) u_wcy (
    .clk(clk), .rst_n(rst_q_n), .start(expire),
    .tick(st_q == ST_WRITE), .zero(wcy_zero)
  );

  pgwr_pbuf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_q_n),
    .ld_en(acc_we), .ld_idx(host_off), .ld_data(host_wdata),
    .clr(wr_done), .rd_idx(idx_q[IDX_W-1:0]), .rd_data(buf_rd)
  );

  pgwr_stat u_stat (
    .clk(clk), .rst_n(rst_q_n), .busy(busy), .rd_en(host_re),
    .arr_rdata(arr_rdata), .last_b7(last_b7_q), .rdata(host_rdata)
  );

  assign busy      = (st_q == ST_WRITE);
  assign page_err  = err_q;
  assign arr_we    = busy && (idx_q < PAGE_CNT);
  assign arr_addr  = busy ? {page_q, idx_q[IDX_W-1:0]} : host_addr;
  assign arr_wdata = buf_rd;
endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
  parameter int ADDR_W     = 18,
  parameter int PAGE_BYTES = 128,
  parameter int WR_CYC     = 300
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_re,
  input logic [7:0]        host_rdata,
  input logic              busy,
  input logic              page_err,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              last_b7
);
  logic [31:0] we_cnt_q, bsy_cnt_q;
  logic        seen_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_cnt_q  <= '0;
      bsy_cnt_q <= '0;
      seen_rd_q <= 1'b0;
    end else if (!busy) begin
      we_cnt_q  <= '0;
      bsy_cnt_q <= '0;
      seen_rd_q <= 1'b0;
    end else begin
      we_cnt_q  <= we_cnt_q + {31'd0, arr_we};
      bsy_cnt_q <= bsy_cnt_q + 32'd1;
      if (host_re) seen_rd_q <= 1'b1;
    end
  end

  // R4
  we_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (we_cnt_q == 32'(PAGE_BYTES)));
  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bsy_cnt_q == 32'(WR_CYC)));
  // R4
  first_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (arr_we && (arr_addr[$clog2(PAGE_BYTES)-1:0] == '0)));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr == $past(arr_addr) + 1'b1));
  // R6
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
  // R7
  inv_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_re) |=> (host_rdata[7] == !$past(last_b7)) &&
                          (host_rdata[5:0] == 6'd0));
  // R8
  tgl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_re && !seen_rd_q) |=> !host_rdata[6]);
  // R8
  tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_re && seen_rd_q) |=> (host_rdata[6] != $past(host_rdata[6])));
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_re) |-> $stable(host_rdata));
endmodule

bind pgwr_seq pgwr_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYC(WR_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_re(host_re), .host_rdata(host_rdata),
  .busy(busy), .page_err(page_err), .arr_we(arr_we), .arr_addr(arr_addr),
  .last_b7(last_b7_q)
);

// File: tb/tb_pgwr_seq.sv
`timescale 1ns/1ps
module tb_pgwr_seq;
  localparam int AW  = 18;
  localparam int PB  = 128;
  localparam int WIN = 20;
  localparam int WRC = 300;

  logic          clk, rst_n, host_we, host_re;
  logic [AW-1:0] host_addr, arr_addr;
  logic [7:0]    host_wdata, host_rdata, arr_wdata, arr_rdata;
  logic          busy, page_err, arr_we;

  int n_chk, n_bad, we_cnt, bcyc, mem_gen;
  logic [7:0] mem [logic [AW-1:0]];
  logic [7:0] rv;
  bit done;

  pgwr_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .LOAD_WIN(WIN), .WR_CYC(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .page_err(page_err), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (busy) bcyc++;
    if (arr_we) begin
      mem[arr_addr] = arr_wdata;
      we_cnt++;
      mem_gen++;
    end
  end

  always @(arr_addr or mem_gen)
    arr_rdata = mem.exists(arr_addr) ? mem[arr_addr] : 8'hFF;

  function automatic logic [AW-1:0] pa(input int pg, input int off);
    return {pg[AW-8:0], off[6:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [7:0] d);
    mem[a] = d;
    mem_gen++;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_busy(input logic v);
    for (int i = 0; i < 2000 && busy != v; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk(page_err == 1'b0, "R10 page_err", page_err, 0);
    chk(arr_we == 1'b0, "R10 arr_we", arr_we, 0);
    chk(host_rdata == 8'h00, "R10 host_rdata", host_rdata, 0);
  endtask

  task automatic t_commit;
    poke(pa(3, 7), 8'h3C);
    rd(pa(3, 7), rv);
    chk(rv == 8'h3C, "R9 idle read", rv, 8'h3C);
    bcyc = 0; we_cnt = 0;
    wr(pa(5, 9), 8'hA5);
    wr(pa(5, 0), 8'h12);
    wr(pa(5, 127), 8'h3C);
    repeat (WIN - 1) @(negedge clk);
    chk(busy == 1'b0, "R3 busy before window end", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R3 busy at window end", busy, 1);
    rd(pa(5, 127), rv);
    chk(rv[7] == 1'b1, "R7 inverted bit7", rv[7], 1);
    chk(rv[5:0] == 6'd0, "R7 low bits zero", rv[5:0], 0);
    chk(rv[6] == 1'b0, "R8 first toggle", rv[6], 0);
    rd(pa(5, 127), rv);
    chk(rv[6] == 1'b1, "R8 second toggle", rv[6], 1);
    rd(pa(2, 2), rv);
    chk(rv[6] == 1'b0, "R8 third toggle", rv[6], 0);
    wait_busy(1'b0);
    chk(bcyc == WRC, "R4 busy length", bcyc, WRC);
    chk(we_cnt == PB, "R4 write pulses", we_cnt, PB);
    rd(pa(5, 9), rv);
    chk(rv == 8'hA5, "R1 offset 9", rv, 8'hA5);
    rd(pa(5, 0), rv);
    chk(rv == 8'h12, "R1 offset 0", rv, 8'h12);
    rd(pa(5, 127), rv);
    chk(rv == 8'h3C, "R9 true data after commit", rv, 8'h3C);
    rd(pa(5, 50), rv);
    chk(rv == 8'hFF, "R2 unloaded offset", rv, 8'hFF);
  endtask

  task automatic t_restart;
    poke(pa(6, 60), 8'h00);
    wr(pa(6, 1), 8'h80);
    repeat (WIN - 3) @(negedge clk);
    wr(pa(6, 2), 8'h81);
    repeat (WIN - 1) @(negedge clk);
    chk(busy == 1'b0, "R3 window restarted", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R3 busy after restart", busy, 1);
    rd(pa(6, 2), rv);
    chk(rv[7] == 1'b0, "R7 inverted bit7 of 81", rv[7], 0);
    wait_busy(1'b0);
    rd(pa(6, 1), rv);
    chk(rv == 8'h80, "R1 first byte", rv, 8'h80);
    rd(pa(6, 2), rv);
    chk(rv == 8'h81, "R1 second byte", rv, 8'h81);
    rd(pa(6, 60), rv);
    chk(rv == 8'hFF, "R2 stale offset filled", rv, 8'hFF);
  endtask

  task automatic t_mismatch;
    poke(pa(8, 4), 8'h77);
    wr(pa(7, 4), 8'h11);
    wr(pa(8, 4), 8'h22);
    chk(page_err == 1'b1, "R5 page_err set", page_err, 1);
    wait_busy(1'b1);
    wait_busy(1'b0);
    rd(pa(8, 4), rv);
    chk(rv == 8'h77, "R5 foreign page untouched", rv, 8'h77);
    rd(pa(7, 4), rv);
    chk(rv == 8'h11, "R5 own page byte", rv, 8'h11);
    chk(page_err == 1'b1, "R5 page_err sticky", page_err, 1);
  endtask

  task automatic t_busy_write;
    poke(pa(9, 3), 8'h5A);
    bcyc = 0;
    wr(pa(10, 3), 8'hC0);
    wait_busy(1'b1);
    wr(pa(9, 3), 8'h00);
    wait_busy(1'b0);
    chk(bcyc == WRC, "R4 busy length second", bcyc, WRC);
    repeat (WIN + 5) @(negedge clk);
    chk(busy == 1'b0, "R6 no load opened", busy, 0);
    rd(pa(9, 3), rv);
    chk(rv == 8'h5A, "R6 busy write ignored", rv, 8'h5A);
    rd(pa(10, 3), rv);
    chk(rv == 8'hC0, "R1 page 10 byte", rv, 8'hC0);
  endtask

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_re = 1'b0;
    host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_commit;
    t_restart;
    t_mismatch;
    t_busy_write;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule